// File: doc/BRIEF.md
# Auxiliary RAM Burst Copy Engine

The engine copies blocks of data between main memory and an auxiliary RAM. Software programs it through a 16-bit register port. Three register pairs hold the main-memory address, the auxiliary-RAM address and the transfer length. Each pair is split into an upper and a lower 16-bit word. The upper length word also holds the direction bit. Addresses and lengths are always whole multiples of 32 bytes, because the low five bits are dropped when the registers are written.

Writing the lower length word while the engine is idle launches a copy. The copy runs as a sequence of 32-byte bursts. Each burst is one read request on the source port followed by one write request on the destination port. Both addresses then step by 32 and the remaining length drops by 32. A control word reports a busy flag and a done flag, and holds the done-interrupt mask. The done flag is cleared by writing one to it. The interrupt line is high while the done flag and the mask are both set.

Top module: `aux_dma_engine`

## Requirements
- R1: After reset, every register reads zero, no transfer runs, the done and mask bits are 0 and `irq` is low.
- R2: Upper address and length words keep only bits 9:0. Lower words keep only bits 15:5, and bits 4:0 read back as 0. Memory addresses presented on either port therefore always have bits 4:0 at 0.
- R3: A write to the lower length word (select 6) while idle starts a transfer using the held addresses, length and direction. Control bit 9 then reads 1 from the next cycle until the final burst completes.
- R4: With direction bit 15 of the upper length word (select 5) at 1, each burst reads the auxiliary RAM and writes the same 256-bit data to main memory. Only one port requests at a time.
- R5: With the direction bit at 0, each burst reads main memory and writes the same data to the auxiliary RAM.
- R6: A transfer of length L issues L/32 bursts. Burst k uses base address + 32*k on both ports, and a port's address is held while its request waits for acknowledge.
- R7: Control bit 5 (done) is set in the same cycle that busy falls. Writing 1 to bit 5 of the control word (select 0) clears it.
- R8: Control bit 6 is the interrupt mask, written by every control-word write. `irq` equals done AND mask.
- R9: Starting with a zero length (including a lower word whose only set bits are 4:0) sets done at once, never raises busy and issues no memory request.
- R10: Register writes during a transfer update the held values, which read back afterwards, but do not change the running transfer. A lower-length write while busy starts nothing.
- R11: Control-word bits other than 5 and 6 have no effect on writes. Writing 0 to bit 5 leaves done unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1/2 main addr hi/lo, 3/4 aux addr hi/lo, 5/6 length hi/lo |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq | output | 1 | Transfer-done interrupt |
| mm_req | output | 1 | Main-memory burst request |
| mm_we | output | 1 | Main-memory request is a write |
| mm_addr | output | 26 | Main-memory burst address |
| mm_wdata | output | 256 | Main-memory write data |
| mm_rdata | input | 256 | Main-memory read data, valid with ack |
| mm_ack | input | 1 | Main-memory burst acknowledge |
| ar_req | output | 1 | Auxiliary-RAM burst request |
| ar_we | output | 1 | Auxiliary-RAM request is a write |
| ar_addr | output | 26 | Auxiliary-RAM burst address |
| ar_wdata | output | 256 | Auxiliary-RAM write data |
| ar_rdata | input | 256 | Auxiliary-RAM read data, valid with ack |
| ar_ack | input | 1 | Auxiliary-RAM burst acknowledge |

## Verification
The bench targets register writes made while a copy is running. A design that restarts on the second lower-length write, or that picks up a new address in mid-copy, writes into a region that must stay untouched.

It also targets zero lengths and lower-length words whose only set bits are 4:0. A design that does not mask those bits, or that always runs at least one burst, raises a request or the busy bit where none is expected.

The control word is written with the neighbouring pending bits set and with bit 5 clear. A design that clears done on any write, or that lets those bits disturb the mask, shows the wrong done or `irq` value.

Acknowledges arrive after random delays in both directions. A design that samples read data outside the acknowledge cycle, or that steps an address before its burst completes, then produces wrong memory contents and address mismatches against the per-cycle model.

// File: rtl/aux_dma_engine.sv
module aux_dma_engine #(
  parameter int HI_BITS = 10,
  parameter int BURST_BYTES = 32,
  localparam int AW = 16 + HI_BITS,
  localparam int DW = 8 * BURST_BYTES,
  localparam int OFS = $clog2(BURST_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq,
  output logic          mm_req,
  output logic          mm_we,
  output logic [AW-1:0] mm_addr,
  output logic [DW-1:0] mm_wdata,
  input  logic [DW-1:0] mm_rdata,
  input  logic          mm_ack,
  output logic          ar_req,
  output logic          ar_we,
  output logic [AW-1:0] ar_addr,
  output logic [DW-1:0] ar_wdata,
  input  logic [DW-1:0] ar_rdata,
  input  logic          ar_ack
);

  typedef enum logic [1:0] {S_IDLE, S_SRC, S_DST} st_t;

  st_t st;
  logic [AW-1:0] mm_h, ar_h, len_h, mm_c, ar_c, rem_c;
  logic dir_h, dir_c, done_q, mask_q;
  logic [DW-1:0] buf_q;
  logic busy;

  assign busy = (st != S_IDLE);

  wire wr_ctl   = reg_wr && reg_sel == 3'd0;
  wire wr_lenlo = reg_wr && reg_sel == 3'd6;
  wire start    = wr_lenlo && !busy;
  wire [AW-1:0] len_new = {len_h[AW-1:16], reg_wdata[15:OFS], {OFS{1'b0}}};
  wire src_ack  = dir_c ? ar_ack : mm_ack;
  wire dst_ack  = dir_c ? mm_ack : ar_ack;
  wire last     = (rem_c == AW'(BURST_BYTES));
  wire fin      = (st == S_DST) && dst_ack && last;
  wire zero_go  = start && (len_new == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_h <= '0; ar_h <= '0; len_h <= '0; dir_h <= 1'b0; mask_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_sel)
        3'd0: mask_q <= reg_wdata[6];
        3'd1: mm_h[AW-1:16] <= reg_wdata[HI_BITS-1:0];
        3'd2: mm_h[15:OFS] <= reg_wdata[15:OFS];
        3'd3: ar_h[AW-1:16] <= reg_wdata[HI_BITS-1:0];
        3'd4: ar_h[15:OFS] <= reg_wdata[15:OFS];
        3'd5: begin
          len_h[AW-1:16] <= reg_wdata[HI_BITS-1:0];
          dir_h <= reg_wdata[15];
        end
        3'd6: len_h[15:OFS] <= reg_wdata[15:OFS];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mm_c <= '0; ar_c <= '0; rem_c <= '0; dir_c <= 1'b0; buf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && !zero_go) begin
          mm_c <= mm_h; ar_c <= ar_h; rem_c <= len_new; dir_c <= dir_h; st <= S_SRC;
        end
        S_SRC: if (src_ack) begin
          buf_q <= dir_c ? ar_rdata : mm_rdata;
          st <= S_DST;
        end
        S_DST: if (dst_ack) begin
          mm_c  <= mm_c + AW'(BURST_BYTES);
          ar_c  <= ar_c + AW'(BURST_BYTES);
          rem_c <= rem_c - AW'(BURST_BYTES);
          st    <= last ? S_IDLE : S_SRC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else if (fin || zero_go) done_q <= 1'b1;
    else if (wr_ctl && reg_wdata[5]) done_q <= 1'b0;
  end

  assign irq      = done_q && mask_q;
  assign mm_req   = (st == S_SRC && !dir_c) || (st == S_DST && dir_c);
  assign ar_req   = (st == S_SRC && dir_c) || (st == S_DST && !dir_c);
  assign mm_we    = (st == S_DST);
  assign ar_we    = (st == S_DST);
  assign mm_addr  = mm_c;
  assign ar_addr  = ar_c;
  assign mm_wdata = buf_q;
  assign ar_wdata = buf_q;

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {6'b0, busy, 2'b0, mask_q, done_q, 5'b0};
      3'd1:    reg_rdata = 16'(mm_h[AW-1:16]);
      3'd2:    reg_rdata = mm_h[15:0];
      3'd3:    reg_rdata = 16'(ar_h[AW-1:16]);
      3'd4:    reg_rdata = ar_h[15:0];
      3'd5:    reg_rdata = {dir_h, 15'(len_h[AW-1:16])};
      3'd6:    reg_rdata = len_h[15:0];
      default: reg_rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/aux_dma_engine_chk.sv
module aux_dma_engine_chk #(
  parameter int AW = 26,
  parameter int OFS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mm_req,
  input logic          mm_ack,
  input logic [AW-1:0] mm_addr,
  input logic          ar_req,
  input logic          ar_ack,
  input logic [AW-1:0] ar_addr
);

  p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_req && ar_req));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mm_req && !ar_req));

  p_mm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_ack) |=> (mm_req && $stable(mm_addr)));

  p_ar_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_req && !ar_ack) |=> (ar_req && $stable(ar_addr)));

  p_finish_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_mm_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req |-> (mm_addr[OFS-1:0] == '0));

  p_ar_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_req |-> (ar_addr[OFS-1:0] == '0));

endmodule

bind aux_dma_engine aux_dma_engine_chk #(.AW(AW), .OFS(OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q),
  .mm_req(mm_req), .mm_ack(mm_ack), .mm_addr(mm_addr),
  .ar_req(ar_req), .ar_ack(ar_ack), .ar_addr(ar_addr)
);

// File: tb/aux_dma_engine_tb_top.sv
`timescale 1ns/1ps
module aux_dma_engine_tb_top;
  localparam int AW = 26;
  localparam int DW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic irq;
  logic mm_req, mm_we, ar_req, ar_we;
  logic mm_ack = 1'b0, ar_ack = 1'b0;
  logic [AW-1:0] mm_addr, ar_addr;
  logic [DW-1:0] mm_wdata, ar_wdata;
  logic [DW-1:0] mm_rdata = '0, ar_rdata = '0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  aux_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_ack(mm_ack),
    .ar_req(ar_req), .ar_we(ar_we), .ar_addr(ar_addr), .ar_wdata(ar_wdata),
    .ar_rdata(ar_rdata), .ar_ack(ar_ack)
  );

  logic [DW-1:0] mmem [int];
  logic [DW-1:0] amem [int];

  function automatic logic [DW-1:0] pat(bit side, logic [AW-1:0] a);
    return {8{side, 5'b10101, a}};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st;
  logic [AW-1:0] m_mm_h, m_ar_h, m_len_h, m_mm, m_ar, m_rem;
  bit m_dir_h, m_dir, m_done, m_mask;

  always @(posedge clk) begin
    int old;
    bit set;
    set = 0;
    old = m_st;
    if (!rst_n) begin
      m_st = 0; m_mm_h = '0; m_ar_h = '0; m_len_h = '0; m_mm = '0; m_ar = '0;
      m_rem = '0; m_dir_h = 0; m_dir = 0; m_done = 0; m_mask = 0;
    end else begin
      if (old == 1 && (m_dir ? ar_ack : mm_ack)) m_st = 2;
      if (old == 2 && (m_dir ? mm_ack : ar_ack)) begin
        m_mm = m_mm + 32; m_ar = m_ar + 32; m_rem = m_rem - 32;
        if (m_rem == 0) begin m_st = 0; set = 1; end else m_st = 1;
      end
      if (reg_wr) begin
        case (reg_sel)
          3'd0: begin if (reg_wdata[5]) m_done = 0; m_mask = reg_wdata[6]; end
          3'd1: m_mm_h[25:16] = reg_wdata[9:0];
          3'd2: m_mm_h[15:5] = reg_wdata[15:5];
          3'd3: m_ar_h[25:16] = reg_wdata[9:0];
          3'd4: m_ar_h[15:5] = reg_wdata[15:5];
          3'd5: begin m_len_h[25:16] = reg_wdata[9:0]; m_dir_h = reg_wdata[15]; end
          3'd6: begin
            m_len_h[15:5] = reg_wdata[15:5];
            if (old == 0) begin
              if (m_len_h == 0) set = 1;
              else begin
                m_mm = m_mm_h; m_ar = m_ar_h; m_rem = m_len_h; m_dir = m_dir_h; m_st = 1;
              end
            end
          end
          default: ;
        endcase
      end
      if (set) m_done = 1;
    end
  end

  // per-cycle comparison and memory responders
  always @(negedge clk) begin
    bit e_mm, e_ar;
    if (rst_n) begin
      e_mm = (m_st == 1 && !m_dir) || (m_st == 2 && m_dir);
      e_ar = (m_st == 1 && m_dir) || (m_st == 2 && !m_dir);
      chk("R6/R9 mm_req", DW'(mm_req), DW'(e_mm));
      chk("R6/R9 ar_req", DW'(ar_req), DW'(e_ar));
      if (mm_req) begin
        chk("R6 mm_addr", DW'(mm_addr), DW'(m_mm));
        chk("R4 mm_we", DW'(mm_we), DW'(m_st == 2));
      end
      if (ar_req) begin
        chk("R6 ar_addr", DW'(ar_addr), DW'(m_ar));
        chk("R5 ar_we", DW'(ar_we), DW'(m_st == 2));
      end
      chk("R8 irq", DW'(irq), DW'(m_done && m_mask));
      if (reg_sel == 3'd0)
        chk("R3 ctrl", DW'(reg_rdata),
            DW'({6'b0, m_st != 0, 2'b0, m_mask, m_done, 5'b0}));
    end
    if (mm_req && !mm_ack && $urandom_range(0, 1) == 1) begin
      mm_ack = 1'b1;
      if (mm_we) mmem[int'(mm_addr >> 5)] = mm_wdata;
      else mm_rdata = mmem.exists(int'(mm_addr >> 5)) ? mmem[int'(mm_addr >> 5)] : pat(0, mm_addr);
    end else mm_ack = 1'b0;
    if (ar_req && !ar_ack && $urandom_range(0, 1) == 1) begin
      ar_ack = 1'b1;
      if (ar_we) amem[int'(ar_addr >> 5)] = ar_wdata;
      else ar_rdata = amem.exists(int'(ar_addr >> 5)) ? amem[int'(ar_addr >> 5)] : pat(1, ar_addr);
    end else ar_ack = 1'b0;
  end

  task automatic wr(logic [2:0] sel, logic [15:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0; reg_sel = 3'd0;
  endtask

  task automatic rd(logic [2:0] sel, logic [15:0] exp, string tag);
    @(negedge clk); #1;
    reg_sel = sel;
    @(negedge clk);
    chk(tag, DW'(reg_rdata), DW'(exp));
    #1 reg_sel = 3'd0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (m_st != 0 && n < 5000);
    if (n >= 5000) chk("R3 transfer completes", 1, 0);
    #1;
  endtask

  task automatic check_copy(bit src_ar, logic [AW-1:0] s, logic [AW-1:0] d, int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] sa, da;
      logic [DW-1:0] act;
      sa = s + AW'(32 * i);
      da = d + AW'(32 * i);
      if (src_ar) act = mmem.exists(int'(da >> 5)) ? mmem[int'(da >> 5)] : '0;
      else act = amem.exists(int'(da >> 5)) ? amem[int'(da >> 5)] : '0;
      chk(tag, act, pat(src_ar, sa));
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 7; s++) rd(3'(s), 16'h0000, "R1 reset readback");
    chk("R1 irq low", DW'(irq), DW'(0));

    // R2 masking
    wr(3'd1, 16'hFFFF); rd(3'd1, 16'h03FF, "R2 main hi mask");
    wr(3'd2, 16'hFFFF); rd(3'd2, 16'hFFE0, "R2 main lo mask");
    wr(3'd5, 16'hFFFF); rd(3'd5, 16'h83FF, "R2 length hi mask");
    wr(3'd5, 16'h0000);

    // R5 R6: main -> aux, 3 bursts, mask off
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0040);
    wr(3'd3, 16'h0000); wr(3'd4, 16'h2000);
    wr(3'd6, 16'h0060);
    wait_idle();
    check_copy(0, 26'h0010040, 26'h0002000, 3, "R5 copy main to aux");
    chk("R8 irq masked", DW'(irq), DW'(0));
    rd(3'd0, 16'h0020, "R7 done after copy");
    wr(3'd0, 16'h0040);
    chk("R8 irq with mask", DW'(irq), DW'(1));

    // R11 other bits and bit5=0 have no effect
    wr(3'd0, 16'h00C8);
    rd(3'd0, 16'h0060, "R11 other bits ignored");
    wr(3'd0, 16'h0060);
    rd(3'd0, 16'h0040, "R7 write one clears done");
    chk("R8 irq after clear", DW'(irq), DW'(0));

    // R4 R10: aux -> main, 4 bursts, writes while busy
    wr(3'd3, 16'h0010); wr(3'd4, 16'h0000);
    wr(3'd1, 16'h0020); wr(3'd2, 16'h0100);
    wr(3'd5, 16'h8000);
    wr(3'd6, 16'h0080);
    wr(3'd2, 16'h4000);
    wr(3'd6, 16'h0200);
    wait_idle();
    check_copy(1, 26'h0100000, 26'h0200100, 4, "R4 copy aux to main");
    chk("R10 no stray write", DW'(mmem.exists(int'(26'h0204000 >> 5))), DW'(0));
    rd(3'd2, 16'h4000, "R10 held main lo");
    rd(3'd6, 16'h0200, "R10 held length lo");
    rd(3'd5, 16'h8000, "R10 held length hi");
    wr(3'd0, 16'h0060);

    // R9 zero length, and low bits only
    wr(3'd6, 16'h0000);
    rd(3'd0, 16'h0060, "R9 zero length done");
    chk("R9 irq on zero length", DW'(irq), DW'(1));
    wr(3'd0, 16'h0060);
    wr(3'd6, 16'h001F);
    rd(3'd0, 16'h0060, "R9 sub-burst length is zero");
    rd(3'd6, 16'h0000, "R2 length lo mask");
    wr(3'd0, 16'h0040);

    // R5 R6: longer copy, 16 bursts, irq raised at end
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'h0030); wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0008); wr(3'd4, 16'h0000);
    wr(3'd6, 16'h0200);
    wait_idle();
    check_copy(0, 26'h0300000, 26'h0080000, 16, "R6 sixteen bursts");
    chk("R8 irq after long copy", DW'(irq), DW'(1));

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule